// File: doc/BRIEF.md
# Multi-Zone External Bus Access Sequencer

This block turns read and write requests from an on-chip requester into cycles on an external asynchronous memory bus that is divided into several address zones, each with its own active-low chip select. Every access passes through three phases in a fixed order. In the setup (lead) phase, the zone's chip select is taken low and the address is driven. In the strobe (active) phase, the read or write strobe is asserted. In the hold (trail) phase, chip select and address stay driven after the strobe has been released.

All phase lengths are counted in ticks of a timing clock enable, `tick`. Each zone has its own lengths, set separately for reads and for writes. A per-zone doubling bit stretches all three phases of that zone by a factor of two, for slow devices. A per-zone ready-sampling bit lets a device hold the strobe phase open by keeping `xready` low.

Writes can be posted into a three-entry buffer, so the requester does not wait for the external cycle to finish. A read is held back until every posted write has reached the bus, which keeps the order of accesses.

Top module: `xbus_seq`

## Requirements
- R1: While idle, every `xcs_n` bit is high and both strobes are high. During an access, exactly the chip-select bit of the requested zone is low, and `xa` carries the requested address from the first setup cycle onward.
- R2: The setup phase lasts N ticks, where N is the 3-bit setup field of the zone for the access direction. Field values 1 to 6 give that many ticks. Values 0 and 7 give 6 ticks, which is the maximum.
- R3: The strobe phase lasts (field + 1) ticks, where the field is 3 bits wide. A read drives `xrd_n` low. A write drives `xwe_n` low, raises `xd_oe` and drives the write data on `xd_out`. The two strobes are never low together.
- R4: The hold phase lasts exactly as many ticks as the 2-bit hold field (0 to 3). Chip select and `xa` stay unchanged through it, and chip select goes high when it ends.
- R5: When the zone's doubling bit is 1, the setup, strobe and hold tick counts of that zone are each twice the counts given by R2 to R4.
- R6: When the zone's ready-sampling bit is 1, the strobe phase does not end while `xready` is low, even after its programmed count. When that bit is 0, `xready` has no effect.
- R7: For a read, the value on `xd_in` at the last strobe tick appears on `rsp_rdata`. `rsp_valid` is high for exactly one cycle: the first cycle in which the chip select is high again.
- R8: With `cfg_wbuf_en` = 0, after a write is accepted, `req_ready` stays low until that write's chip select has been released.
- R9: With `cfg_wbuf_en` = 1, while one access is held on the bus, three further writes are accepted. A fourth waits with `req_ready` low.
- R10: A read is not accepted while posted writes are pending or an access is in progress. Posted writes reach the bus in the order they were accepted, all before the read.
- R11: Each zone and each direction uses only its own fields. No phase advances in a cycle where `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing clock enable; phases count these |
| cfg_wbuf_en | input | 1 | Enable posting of writes |
| cfg_x2 | input | NZONE | Per-zone doubling of all phase counts |
| cfg_rdy_en | input | NZONE | Per-zone sampling of `xready` |
| cfg_rd_lead | input | NZONE x 3 | Per-zone read setup field |
| cfg_rd_act | input | NZONE x 3 | Per-zone read strobe field |
| cfg_rd_trail | input | NZONE x 2 | Per-zone read hold field |
| cfg_wr_lead | input | NZONE x 3 | Per-zone write setup field |
| cfg_wr_act | input | NZONE x 3 | Per-zone write strobe field |
| cfg_wr_trail | input | NZONE x 2 | Per-zone write hold field |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | ZW | Target zone |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| xcs_n | output | NZONE | Active-low zone chip selects |
| xa | output | AW | External address |
| xd_out | output | DW | External write data |
| xd_oe | output | 1 | Data bus drive enable |
| xd_in | input | DW | External read data |
| xrd_n | output | 1 | Active-low read strobe |
| xwe_n | output | 1 | Active-low write strobe |
| xready | input | 1 | Device ready |

## Verification
The assertions check a set of properties on every cycle: at most one chip select is low, the strobes are exclusive, a strobe only appears while a chip select is low, and the address is stable for the whole chip-select window. They also check that nothing on the bus moves in a cycle without a tick, that a zone with ready sampling enabled holds its strobe while `xready` is low, that requests stall while buffering is off, and that reads are only accepted with the bus idle. The exact tick count of each phase, the fallback setup value, the doubling, the per-zone and per-direction selection, the captured read data, and the order in which posted writes and a trailing read reach the bus can only be shown by the bench scenarios. The bench measures these at the pins.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CNT_W    = 5;
    localparam int LEAD_MAX = 6;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_ACT   = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] trail;
    } timing_t;

    function automatic logic [CNT_W-1:0] stretch(input logic [CNT_W-1:0] b, input logic x2);
        return x2 ? (b << 1) : b;
    endfunction

    function automatic logic [CNT_W-1:0] lead_ticks(input logic [2:0] f, input logic x2);
        logic [CNT_W-1:0] b;
        b = (f == 3'd0 || f > 3'(LEAD_MAX)) ? CNT_W'(LEAD_MAX) : CNT_W'(f);
        return stretch(b, x2);
    endfunction

    function automatic logic [CNT_W-1:0] act_ticks(input logic [2:0] f, input logic x2);
        return stretch(CNT_W'(f) + CNT_W'(1), x2);
    endfunction

    function automatic logic [CNT_W-1:0] trail_ticks(input logic [1:0] f, input logic x2);
        return stretch(CNT_W'(f), x2);
    endfunction

endpackage

// File: rtl/xbus_timing_sel.sv
module xbus_timing_sel
    import xbus_pkg::*;
#(
    parameter int NZONE = 3,
    parameter int ZW    = 2
) (
    input  logic [NZONE-1:0]       cfg_x2,
    input  logic [NZONE-1:0][2:0]  cfg_rd_lead,
    input  logic [NZONE-1:0][2:0]  cfg_rd_act,
    input  logic [NZONE-1:0][1:0]  cfg_rd_trail,
    input  logic [NZONE-1:0][2:0]  cfg_wr_lead,
    input  logic [NZONE-1:0][2:0]  cfg_wr_act,
    input  logic [NZONE-1:0][1:0]  cfg_wr_trail,
    input  logic [ZW-1:0]          zone,
    input  logic                   is_wr,
    output timing_t                tim
);
    timing_t zt [NZONE];

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        always_comb begin
            if (is_wr) begin
                zt[z].lead  = lead_ticks(cfg_wr_lead[z], cfg_x2[z]);
                zt[z].act   = act_ticks(cfg_wr_act[z], cfg_x2[z]);
                zt[z].trail = trail_ticks(cfg_wr_trail[z], cfg_x2[z]);
            end else begin
                zt[z].lead  = lead_ticks(cfg_rd_lead[z], cfg_x2[z]);
                zt[z].act   = act_ticks(cfg_rd_act[z], cfg_x2[z]);
                zt[z].trail = trail_ticks(cfg_rd_trail[z], cfg_x2[z]);
            end
        end
    end

    always_comb begin
        tim = zt[0];
        for (int z = 1; z < NZONE; z++)
            if (zone == ZW'(z)) tim = zt[z];
    end
endmodule

// File: rtl/xbus_wbuf.sv
module xbus_wbuf #(
    parameter int W     = 31,
    parameter int DEPTH = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slot[wr_ptr] <= push_data;
                wr_ptr       <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = slot[rd_ptr];
endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
    import xbus_pkg::*;
#(
    parameter int ZW = 2,
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic [ZW-1:0] st_zone,
    input  logic          st_wr,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  timing_t       tim,
    input  logic          rdy_en,
    input  logic          xready,
    input  logic [DW-1:0] xd_in,
    output phase_e        ph,
    output logic [ZW-1:0] cur_zone,
    output logic          cur_wr,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_data,
    output logic          rd_done,
    output logic [DW-1:0] rdata
);
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            cur_zone <= '0;
            cur_wr   <= 1'b0;
            cur_addr <= '0;
            cur_data <= '0;
            rd_done  <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_done <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    cur_zone <= st_zone;
                    cur_wr   <= st_wr;
                    cur_addr <= st_addr;
                    cur_data <= st_data;
                    cnt      <= tim.lead;
                    ph       <= PH_LEAD;
                end
                PH_LEAD: if (tick) begin
                    if (last) begin
                        ph  <= PH_ACT;
                        cnt <= tim.act;
                    end else cnt <= cnt - CNT_W'(1);
                end
                PH_ACT: if (tick) begin
                    if (!last) cnt <= cnt - CNT_W'(1);
                    else if (!rdy_en || xready) begin
                        if (!cur_wr) rdata <= xd_in;
                        if (tim.trail == '0) begin
                            ph      <= PH_IDLE;
                            rd_done <= !cur_wr;
                        end else begin
                            ph  <= PH_TRAIL;
                            cnt <= tim.trail;
                        end
                    end
                end
                PH_TRAIL: if (tick) begin
                    if (last) begin
                        ph      <= PH_IDLE;
                        rd_done <= !cur_wr;
                    end else cnt <= cnt - CNT_W'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int NZONE = 3,
    parameter int AW    = 12,
    parameter int DW    = 16,
    parameter int WBUF_DEPTH = 3,
    localparam int ZW   = (NZONE > 1) ? $clog2(NZONE) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   cfg_wbuf_en,
    input  logic [NZONE-1:0]       cfg_x2,
    input  logic [NZONE-1:0]       cfg_rdy_en,
    input  logic [NZONE-1:0][2:0]  cfg_rd_lead,
    input  logic [NZONE-1:0][2:0]  cfg_rd_act,
    input  logic [NZONE-1:0][1:0]  cfg_rd_trail,
    input  logic [NZONE-1:0][2:0]  cfg_wr_lead,
    input  logic [NZONE-1:0][2:0]  cfg_wr_act,
    input  logic [NZONE-1:0][1:0]  cfg_wr_trail,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ZW-1:0]          req_zone,
    input  logic [AW-1:0]          req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    output logic [NZONE-1:0]       xcs_n,
    output logic [AW-1:0]          xa,
    output logic [DW-1:0]          xd_out,
    output logic                   xd_oe,
    input  logic [DW-1:0]          xd_in,
    output logic                   xrd_n,
    output logic                   xwe_n,
    input  logic                   xready
);
    localparam int EW = ZW + AW + DW;
    localparam int CW = $clog2(WBUF_DEPTH + 1);

    typedef struct packed {
        logic [ZW-1:0] zone;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wentry_t;

    phase_e        ph;
    wentry_t       head, in_ent;
    logic [CW-1:0] wb_cnt;
    logic          idle, wb_empty, rd_ok, wr_ok, push, pop, rd_go, start, busy;
    logic [ZW-1:0] cur_zone, st_zone, sel_zone;
    logic          cur_wr, st_wr, sel_wr;
    logic [AW-1:0] cur_addr, st_addr;
    logic [DW-1:0] cur_data, st_data;
    timing_t       tim;

    assign idle     = (ph == PH_IDLE);
    assign busy     = !idle;
    assign wb_empty = (wb_cnt == '0);
    assign rd_ok    = idle && wb_empty;
    assign wr_ok    = cfg_wbuf_en ? (wb_cnt < CW'(WBUF_DEPTH)) : rd_ok;
    assign req_ready = req_write ? wr_ok : rd_ok;
    assign push     = req_valid && req_write && wr_ok;
    assign rd_go    = req_valid && !req_write && rd_ok;
    assign pop      = idle && !wb_empty;
    assign start    = pop || rd_go;
    assign in_ent   = '{zone: req_zone, addr: req_addr, data: req_wdata};

    always_comb begin
        if (pop) begin
            st_zone = head.zone; st_wr = 1'b1; st_addr = head.addr; st_data = head.data;
        end else begin
            st_zone = req_zone;  st_wr = 1'b0; st_addr = req_addr;  st_data = '0;
        end
    end

    assign sel_zone = idle ? st_zone : cur_zone;
    assign sel_wr   = idle ? st_wr   : cur_wr;

    xbus_wbuf #(.W(EW), .DEPTH(WBUF_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst), .push(push), .push_data(in_ent),
        .pop(pop), .head(head), .count(wb_cnt)
    );

    xbus_timing_sel #(.NZONE(NZONE), .ZW(ZW)) u_tsel (
        .cfg_x2(cfg_x2),
        .cfg_rd_lead(cfg_rd_lead), .cfg_rd_act(cfg_rd_act), .cfg_rd_trail(cfg_rd_trail),
        .cfg_wr_lead(cfg_wr_lead), .cfg_wr_act(cfg_wr_act), .cfg_wr_trail(cfg_wr_trail),
        .zone(sel_zone), .is_wr(sel_wr), .tim(tim)
    );

    xbus_phase_fsm #(.ZW(ZW), .AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .st_zone(st_zone), .st_wr(st_wr), .st_addr(st_addr), .st_data(st_data),
        .tim(tim), .rdy_en(cfg_rdy_en[cur_zone]), .xready(xready), .xd_in(xd_in),
        .ph(ph), .cur_zone(cur_zone), .cur_wr(cur_wr), .cur_addr(cur_addr),
        .cur_data(cur_data), .rd_done(rsp_valid), .rdata(rsp_rdata)
    );

    for (genvar z = 0; z < NZONE; z++) begin : g_cs
        assign xcs_n[z] = !(busy && cur_zone == ZW'(z));
    end

    assign xa     = busy ? cur_addr : '0;
    assign xd_out = cur_data;
    assign xrd_n  = !(ph == PH_ACT && !cur_wr);
    assign xwe_n  = !(ph == PH_ACT && cur_wr);
    assign xd_oe  = (ph == PH_ACT) && cur_wr;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int NZONE = 3,
    parameter int AW    = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cfg_wbuf_en,
    input logic [NZONE-1:0] cfg_rdy_en,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [NZONE-1:0] xcs_n,
    input logic [AW-1:0]    xa,
    input logic             xd_oe,
    input logic             xrd_n,
    input logic             xwe_n,
    input logic             xready
);
    logic in_acc, strobe, rdy_zone;
    assign in_acc   = (xcs_n != '1);
    assign strobe   = !xrd_n || !xwe_n;
    assign rdy_zone = |(~xcs_n & cfg_rdy_en);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~xcs_n)); // R1
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        strobe |-> in_acc); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!xrd_n && !xwe_n)); // R3
    AST_OE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        xd_oe |-> !xwe_n); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (in_acc && $past(xcs_n) == xcs_n) |-> $stable(xa)); // R4
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (strobe && rdy_zone && !xready) |=> ($stable(xrd_n) && $stable(xwe_n))); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7
    AST_WBUF_OFF_STALL: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wbuf_en && in_acc) |-> !req_ready); // R8
    AST_READ_WAITS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_ready) |-> !in_acc); // R10
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && in_acc) |=> ($stable(xcs_n) && $stable(xrd_n) && $stable(xwe_n))); // R11
endmodule

bind xbus_seq xbus_seq_chk #(.NZONE(NZONE), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cfg_wbuf_en(cfg_wbuf_en), .cfg_rdy_en(cfg_rdy_en),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .xcs_n(xcs_n), .xa(xa), .xd_oe(xd_oe),
    .xrd_n(xrd_n), .xwe_n(xwe_n), .xready(xready)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
    localparam int NZONE = 3, AW = 12, DW = 16, ZW = 2;

    logic clk = 0, rst = 1, tick = 0, tick_en = 1;
    logic cfg_wbuf_en = 0;
    logic [NZONE-1:0] cfg_x2 = '0, cfg_rdy_en = '0;
    logic [NZONE-1:0][2:0] cfg_rd_lead = '0, cfg_rd_act = '0, cfg_wr_lead = '0, cfg_wr_act = '0;
    logic [NZONE-1:0][1:0] cfg_rd_trail = '0, cfg_wr_trail = '0;
    logic req_valid = 0, req_write = 0;
    logic [ZW-1:0] req_zone = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, xd_oe, xrd_n, xwe_n;
    logic xready = 1;
    logic [DW-1:0] rsp_rdata, xd_out, xd_in;
    logic [NZONE-1:0] xcs_n;
    logic [AW-1:0] xa;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    assign xd_in = xrd_n ? '0 : (16'h5000 ^ {4'h0, xa});

    xbus_seq #(.NZONE(NZONE), .AW(AW), .DW(DW), .WBUF_DEPTH(3)) u_dut (.*);

    initial forever begin
        @(posedge clk); #1;
        tick = tick_en ? ~tick : 1'b0;
    end

    // pin-level monitor
    logic prev_in = 0, seen = 0;
    int m_lead, m_act, m_trail, m_zone, acc_cnt = 0;
    int l_lead, l_act, l_trail, l_zone;
    logic [AW-1:0] m_addr, log_addr [0:31];
    logic [DW-1:0] m_wdata, log_data [0:31];
    logic m_wr, log_wr [0:31];

    always @(negedge clk) begin
        if (xcs_n != '1) begin
            if (!prev_in) begin
                m_lead = 0; m_act = 0; m_trail = 0; seen = 0; m_wr = 0;
                m_addr = xa;
                for (int z = 0; z < NZONE; z++) if (!xcs_n[z]) m_zone = z;
            end
            if (!xrd_n || !xwe_n) begin
                seen = 1;
                if (tick) m_act++;
                if (!xwe_n) begin m_wr = 1; m_wdata = xd_out; end
            end else if (seen) begin
                if (tick) m_trail++;
            end else if (tick) m_lead++;
            prev_in = 1;
        end else if (prev_in) begin
            prev_in = 0;
            l_lead = m_lead; l_act = m_act; l_trail = m_trail; l_zone = m_zone;
            if (acc_cnt < 32) begin
                log_addr[acc_cnt] = m_addr; log_data[acc_cnt] = m_wdata; log_wr[acc_cnt] = m_wr;
            end
            acc_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input int zone, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_zone = ZW'(zone); req_addr = a; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_acc(input int n);
        while (acc_cnt < n) @(negedge clk);
    endtask

    logic [DW-1:0] got_rd;
    task automatic wait_rsp();
        do @(negedge clk); while (!rsp_valid);
        got_rd = rsp_rdata;
    endtask

    task automatic cfg_default();
        cfg_x2 = '1; cfg_rdy_en = '0;
        for (int z = 0; z < NZONE; z++) begin
            cfg_rd_lead[z] = 3'd1; cfg_rd_act[z] = 3'd0; cfg_rd_trail[z] = 2'd0;
            cfg_wr_lead[z] = 3'd1; cfg_wr_act[z] = 3'd0; cfg_wr_trail[z] = 2'd0;
        end
    endtask

    typedef struct packed {
        logic [1:0] zone; logic wr; logic x2;
        logic [2:0] lf; logic [2:0] af; logic [1:0] tf;
        logic [11:0] addr; logic [15:0] data;
        logic [4:0] el; logic [4:0] ea; logic [4:0] et;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 12'h123, 16'h0000, 5'd6,  5'd1, 5'd0},
        '{2'd1, 1'b1, 1'b0, 3'd3, 3'd2, 2'd1, 12'h456, 16'hBEEF, 5'd3,  5'd3, 5'd1},
        '{2'd2, 1'b0, 1'b1, 3'd2, 3'd1, 2'd2, 12'h789, 16'h0000, 5'd4,  5'd4, 5'd4},
        '{2'd0, 1'b1, 1'b1, 3'd7, 3'd3, 2'd3, 12'hABC, 16'h1234, 5'd12, 5'd8, 5'd6},
        '{2'd1, 1'b0, 1'b0, 3'd1, 3'd7, 2'd3, 12'h0F0, 16'h0000, 5'd1,  5'd8, 5'd3},
        '{2'd2, 1'b1, 1'b0, 3'd6, 3'd0, 2'd0, 12'hFFF, 16'hA5A5, 5'd6,  5'd1, 5'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        cfg_default();
        repeat (3) @(posedge clk); #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset cs", int'(xcs_n), 7);
        chk("R1 reset strobes", int'({xrd_n, xwe_n}), 3);
        chk("R3 reset oe", int'(xd_oe), 0);
        chk("R7 reset rsp", int'(rsp_valid), 0);

        // table walk: R2 R3 R4 R5 R11 and R7 read data
        foreach (VEC[i]) begin
            vec_t v = VEC[i];
            cfg_default();
            cfg_x2[v.zone] = v.x2;
            if (v.wr) begin
                cfg_wr_lead[v.zone] = v.lf; cfg_wr_act[v.zone] = v.af; cfg_wr_trail[v.zone] = v.tf;
            end else begin
                cfg_rd_lead[v.zone] = v.lf; cfg_rd_act[v.zone] = v.af; cfg_rd_trail[v.zone] = v.tf;
            end
            base = acc_cnt;
            issue(v.wr, int'(v.zone), v.addr, v.data);
            if (!v.wr) begin
                wait_rsp();
                chk("R7 rdata", int'(got_rd), int'(16'h5000 ^ {4'h0, v.addr}));
            end
            wait_acc(base + 1);
            chk("R2 R5 R11 lead ticks", l_lead, int'(v.el));
            chk("R3 R5 R11 strobe ticks", l_act, int'(v.ea));
            chk("R4 R5 R11 hold ticks", l_trail, int'(v.et));
            chk("R1 zone", l_zone, int'(v.zone));
            chk("R1 addr", int'(log_addr[base]), int'(v.addr));
            chk("R3 direction", int'(log_wr[base]), int'(v.wr));
            if (v.wr) chk("R3 wdata", int'(log_data[base]), int'(v.data));
        end

        // R8: buffering off stalls until write done
        cfg_default(); cfg_wbuf_en = 0;
        base = acc_cnt;
        issue(1, 0, 12'h011, 16'h0101);
        @(negedge clk);
        chk("R8 stalled", int'(req_ready), 0);
        wait_acc(base + 1);
        chk("R8 released", int'(req_ready), 1);

        // R9: three writes queued behind one on the bus
        cfg_wbuf_en = 1; tick_en = 0;
        base = acc_cnt;
        for (int k = 0; k < 4; k++) issue(1, k % 3, AW'(12'h100 + k), DW'(16'hC000 + k));
        chk("R9 none finished", acc_cnt - base, 0);
        @(posedge clk); #1 req_valid = 1; req_write = 1;
        @(negedge clk);
        chk("R9 fifth waits", int'(req_ready), 0);
        @(posedge clk); #1 req_valid = 0;
        tick_en = 1;
        wait_acc(base + 4);
        for (int k = 0; k < 4; k++) begin
            chk("R9 R10 write order addr", int'(log_addr[base + k]), 12'h100 + k);
            chk("R9 write data", int'(log_data[base + k]), 16'hC000 + k);
        end

        // R10: read waits behind posted writes
        tick_en = 0;
        base = acc_cnt;
        issue(1, 0, 12'h010, 16'h1111);
        issue(1, 1, 12'h020, 16'h2222);
        @(posedge clk); #1 req_valid = 1; req_write = 0; req_zone = 2; req_addr = 12'h030;
        repeat (3) @(negedge clk);
        chk("R10 read held", int'(req_ready), 0);
        tick_en = 1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1 req_valid = 0;
        wait_rsp();
        wait_acc(base + 3);
        chk("R10 first", int'(log_addr[base]), 12'h010);
        chk("R10 second", int'(log_addr[base + 1]), 12'h020);
        chk("R10 read last", int'(log_addr[base + 2]), 12'h030);
        chk("R10 read dir", int'(log_wr[base + 2]), 0);
        chk("R7 rdata after writes", int'(got_rd), 16'h5030);

        // R6: ready sampling enabled extends strobe phase
        cfg_default(); cfg_x2 = '0; cfg_rdy_en[1] = 1; xready = 0;
        base = acc_cnt;
        fork
            issue(0, 1, 12'h055, 16'h0);
            begin
                int n = 0;
                while (n < 5) begin
                    @(negedge clk);
                    if (!xrd_n && tick) begin
                        n++;
                        if (n == 5) xready = 1;
                    end
                end
            end
        join
        wait_acc(base + 1);
        chk("R6 extended strobe", l_act, 5);
        // R6: ready ignored when sampling disabled
        cfg_rdy_en = '0; xready = 0; cfg_rd_act[1] = 3'd2;
        base = acc_cnt;
        issue(0, 1, 12'h066, 16'h0);
        wait_acc(base + 1);
        chk("R6 ready ignored", l_act, 3);
        xready = 1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule